// File: doc/BRIEF.md
# Floor and Truncate Integer Divider

This block divides a dividend by a divisor and returns both a quotient and a remainder. Two rounding conventions are available: rounding toward zero and rounding toward negative infinity. A per-request mode bit selects between them. Each operand carries its own signedness flag. Signed arithmetic applies only when both flags are set; otherwise both operands are taken as unsigned.

The datapath works on operand magnitudes with a multi-cycle shift-subtract loop that produces one quotient bit per clock. A final stage then restores the signs and, when flooring is selected, adjusts the results. A zero divisor never leaves the outputs undefined: it gives fixed values and raises a flag alongside the result.

Requests enter through a valid/ready port. `in_ready` is high only when the block is idle. A request is taken on a clock edge where `in_valid` and `in_ready` are both high, and `in_valid` has no effect at any other time. Results leave through a valid/ready port. When `out_valid` is high and `out_ready` is low, the result is held unchanged and no new request is taken. The block returns to idle on the edge that completes the output handshake.

Top module: `floor_trunc_divider`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A request is taken only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` stays 0 from that edge until the result handshake completes, and `in_valid` during that time changes nothing. `in_ready` and `out_valid` are never 1 together.
- R3: `out_valid` rises exactly RW+1 clock edges after the accepting edge, where RW is the larger of the two operand widths.
- R4: While `out_valid` is 1 and `out_ready` is 0, all result outputs hold their values. On the edge where both are 1, `out_valid` falls and `in_ready` rises.
- R5: With `in_floor`=0, the quotient is rounded toward zero and the remainder has the sign of the dividend, so that q*b+r equals a.
- R6: With `in_floor`=1 and signed operation, when the operand signs differ and the truncated remainder is nonzero, the quotient is the truncated quotient minus one and the remainder is the truncated remainder plus the divisor. In every other case the floored results equal the truncated ones.
- R7: If either signedness flag is 0, both operands are zero-extended unsigned values and the mode bit has no effect on the results.
- R8: With a zero divisor, the unsigned quotient is ones across the dividend width and zeros in any wider result bits. The signed quotient is all ones (-1) for a non-negative dividend and +1 for a negative dividend.
- R9: With a zero divisor, the remainder is the dividend's low min(A_W,B_W) bits, sign-extended if the operation is signed and zero-extended otherwise. `out_div_zero` is 1 with that result and 0 for every nonzero divisor.
- R10: The most negative dividend divided by -1 gives the most negative RW-bit value as the quotient, with remainder 0 and no other indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle, request can be taken |
| in_dividend | input | A_W | Dividend |
| in_divisor | input | B_W | Divisor |
| in_a_signed | input | 1 | Dividend is signed |
| in_b_signed | input | 1 | Divisor is signed |
| in_floor | input | 1 | 1 selects rounding toward negative infinity, 0 selects rounding toward zero |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_quotient | output | RW | Quotient |
| out_remainder | output | RW | Remainder |
| out_div_zero | output | 1 | Divisor was zero |

## Verification
Two things can happen in the same cycle: a new request can arrive while a finished result is still waiting under back-pressure, or while the loop is running. The bench raises `in_valid` with different operands during the busy window and keeps `out_ready` low for several cycles after `out_valid` rises. It then checks that the held quotient, remainder and flag match the original request and that nothing was taken. It also checks that `in_ready` returns exactly one edge after the consuming handshake and that the next result belongs to the next legitimately presented request.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2,
    ST_DONE = 2'd3
  } fdiv_state_e;

  function automatic int max_i(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  function automatic int min_i(input int x, input int y);
    return (x < y) ? x : y;
  endfunction
endpackage

// File: rtl/fdiv_operand_prep.sv
module fdiv_operand_prep #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int RW  = 8
) (
  input  logic [A_W-1:0] a,
  input  logic [B_W-1:0] b,
  input  logic           a_signed,
  input  logic           b_signed,
  output logic           sn,
  output logic           a_neg,
  output logic           b_neg,
  output logic [RW-1:0]  a_mag,
  output logic [RW-1:0]  b_mag,
  output logic [RW-1:0]  b_ext,
  output logic           dz
);
  logic [RW-1:0] a_ext;

  always_comb begin
    sn    = a_signed & b_signed;
    a_ext = sn ? RW'($signed(a)) : RW'(a);
    b_ext = sn ? RW'($signed(b)) : RW'(b);
    a_neg = sn & a[A_W-1];
    b_neg = sn & b[B_W-1];
    a_mag = a_neg ? (~a_ext + RW'(1)) : a_ext;
    b_mag = b_neg ? (~b_ext + RW'(1)) : b_ext;
    dz    = (b == '0);
  end
endmodule

// File: rtl/fdiv_restoring_core.sv
module fdiv_restoring_core #(
  parameter int RW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [RW-1:0] dividend,
  input  logic [RW-1:0] divisor,
  output logic [RW-1:0] quo,
  output logic [RW-1:0] rem
);
  logic [RW-1:0] dvs_q;
  logic [RW:0]   shifted;
  logic [RW:0]   diff;

  always_comb begin
    shifted = {rem, quo[RW-1]};
    diff    = shifted - {1'b0, dvs_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      quo   <= '0;
      rem   <= '0;
      dvs_q <= '0;
    end else if (load) begin
      quo   <= dividend;
      rem   <= '0;
      dvs_q <= divisor;
    end else if (step) begin
      if (!diff[RW]) begin
        rem <= diff[RW-1:0];
        quo <= {quo[RW-2:0], 1'b1};
      end else begin
        rem <= shifted[RW-1:0];
        quo <= {quo[RW-2:0], 1'b0};
      end
    end
  end

  // partial remainder stays below a nonzero divisor after every step
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && dvs_q != '0) |=> (rem < dvs_q)) else $error("rem bound"); // R5
endmodule

// File: rtl/fdiv_sign_fix.sv
module fdiv_sign_fix #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  parameter int RW  = 8
) (
  input  logic [RW-1:0]  qu,
  input  logic [RW-1:0]  ru,
  input  logic           sn,
  input  logic           a_neg,
  input  logic           b_neg,
  input  logic           floor_md,
  input  logic           dz,
  input  logic [A_W-1:0] a_raw,
  input  logic [RW-1:0]  b_ext,
  output logic [RW-1:0]  q,
  output logic [RW-1:0]  r
);
  localparam int MINW = fdiv_pkg::min_i(A_W, B_W);

  logic [MINW-1:0] a_low;
  logic [RW-1:0]   q_tr, r_tr, qu_p1;
  logic            adjust;

  always_comb begin
    a_low  = a_raw[MINW-1:0];
    qu_p1  = qu + RW'(1);
    q_tr   = (a_neg ^ b_neg) ? (~qu + RW'(1)) : qu;
    r_tr   = a_neg ? (~ru + RW'(1)) : ru;
    adjust = floor_md & sn & (a_neg ^ b_neg) & (ru != '0);
    if (dz) begin
      if (sn) q = a_neg ? RW'(1) : '1;
      else    q = RW'({A_W{1'b1}});
      r = sn ? RW'($signed(a_low)) : RW'(a_low);
    end else if (adjust) begin
      q = ~qu_p1 + RW'(1);
      r = r_tr + b_ext;
    end else begin
      q = q_tr;
      r = r_tr;
    end
  end
endmodule

// File: rtl/floor_trunc_divider.sv
module floor_trunc_divider #(
  parameter int A_W = 8,
  parameter int B_W = 8,
  localparam int RW = fdiv_pkg::max_i(A_W, B_W)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [A_W-1:0] in_dividend,
  input  logic [B_W-1:0] in_divisor,
  input  logic           in_a_signed,
  input  logic           in_b_signed,
  input  logic           in_floor,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [RW-1:0]  out_quotient,
  output logic [RW-1:0]  out_remainder,
  output logic           out_div_zero
);
  import fdiv_pkg::*;

  localparam int IW = $clog2(RW) + 1;

  fdiv_state_e   state;
  logic [IW-1:0] iter;
  logic          accept;

  logic          p_sn, p_aneg, p_bneg, p_dz;
  logic [RW-1:0] p_amag, p_bmag, p_bext;

  logic          sn_q, aneg_q, bneg_q, floor_q, dz_q;
  logic [A_W-1:0] araw_q;
  logic [RW-1:0] bext_q;
  logic [RW-1:0] core_q, core_r, fix_q, fix_r;

  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid & in_ready;

  fdiv_operand_prep #(.A_W(A_W), .B_W(B_W), .RW(RW)) prep_i (
    .a(in_dividend), .b(in_divisor), .a_signed(in_a_signed), .b_signed(in_b_signed),
    .sn(p_sn), .a_neg(p_aneg), .b_neg(p_bneg), .a_mag(p_amag), .b_mag(p_bmag),
    .b_ext(p_bext), .dz(p_dz)
  );

  fdiv_restoring_core #(.RW(RW)) core_i (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(state == ST_RUN),
    .dividend(p_amag), .divisor(p_bmag), .quo(core_q), .rem(core_r)
  );

  fdiv_sign_fix #(.A_W(A_W), .B_W(B_W), .RW(RW)) fix_i (
    .qu(core_q), .ru(core_r), .sn(sn_q), .a_neg(aneg_q), .b_neg(bneg_q),
    .floor_md(floor_q), .dz(dz_q), .a_raw(araw_q), .b_ext(bext_q),
    .q(fix_q), .r(fix_r)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state         <= ST_IDLE;
      iter          <= '0;
      sn_q          <= 1'b0;
      aneg_q        <= 1'b0;
      bneg_q        <= 1'b0;
      floor_q       <= 1'b0;
      dz_q          <= 1'b0;
      araw_q        <= '0;
      bext_q        <= '0;
      out_valid     <= 1'b0;
      out_quotient  <= '0;
      out_remainder <= '0;
      out_div_zero  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          state   <= ST_RUN;
          iter    <= '0;
          sn_q    <= p_sn;
          aneg_q  <= p_aneg;
          bneg_q  <= p_bneg;
          floor_q <= in_floor;
          dz_q    <= p_dz;
          araw_q  <= in_dividend;
          bext_q  <= p_bext;
        end
        ST_RUN: begin
          iter <= iter + IW'(1);
          if (iter == IW'(RW - 1)) state <= ST_FIX;
        end
        ST_FIX: begin
          state         <= ST_DONE;
          out_valid     <= 1'b1;
          out_quotient  <= fix_q;
          out_remainder <= fix_r;
          out_div_zero  <= dz_q;
        end
        default: if (out_ready) begin
          state        <= ST_IDLE;
          out_valid    <= 1'b0;
          out_div_zero <= 1'b0;
        end
      endcase
    end
  end

  // latency window counter used only by the checks below
  logic [IW:0] lat_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n)                                    lat_cnt <= '0;
    else if (accept)                               lat_cnt <= '0;
    else if (state == ST_RUN || state == ST_FIX)   lat_cnt <= lat_cnt + (IW+1)'(1);
  end

  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid)) else $error("ready and valid together"); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (lat_cnt == (IW+1)'(RW + 1))) else $error("latency"); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_quotient) &&
      $stable(out_remainder) && $stable(out_div_zero))) else $error("hold"); // R4
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (in_ready && !out_valid)) else $error("release"); // R4
  AST_DZ_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    out_div_zero |-> out_valid) else $error("flag without result"); // R9
endmodule

// File: tb/floor_trunc_divider_tb_top.sv
module floor_trunc_divider_tb_top;
  localparam int A_W  = 8;
  localparam int B_W  = 6;
  localparam int RW   = 8;
  localparam int MINW = 6;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [A_W-1:0] in_dividend = '0;
  logic [B_W-1:0] in_divisor = '0;
  logic           in_a_signed = 1'b0;
  logic           in_b_signed = 1'b0;
  logic           in_floor = 1'b0;
  logic           out_valid;
  logic           out_ready = 1'b0;
  logic [RW-1:0]  out_quotient, out_remainder;
  logic           out_div_zero;

  int n_tests = 0;
  int n_fail  = 0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  floor_trunc_divider #(.A_W(A_W), .B_W(B_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_dividend(in_dividend), .in_divisor(in_divisor),
    .in_a_signed(in_a_signed), .in_b_signed(in_b_signed), .in_floor(in_floor),
    .out_valid(out_valid), .out_ready(out_ready), .out_quotient(out_quotient),
    .out_remainder(out_remainder), .out_div_zero(out_div_zero)
  );

  task automatic check(input string req, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2*RW:0] ref_div(input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                                            input bit sa, input bit sb, input bit fl);
    bit sn = sa && sb;
    longint av, bv, q, r;
    logic [MINW-1:0] low;
    av = sn ? longint'($signed(a)) : longint'(a);
    bv = sn ? longint'($signed(b)) : longint'(b);
    if (bv == 0) begin
      low = a[MINW-1:0];
      if (sn) q = (av < 0) ? 1 : -1;
      else    q = (64'd1 << A_W) - 1;
      r = sn ? longint'($signed(low)) : longint'(low);
    end else begin
      q = av / bv;
      r = av % bv;
      if (fl && r != 0 && ((r < 0) != (bv < 0))) begin
        q = q - 1;
        r = r + bv;
      end
    end
    return {(bv == 0), RW'(q), RW'(r)};
  endfunction

  // one division; hold>0 applies back-pressure, junk raises in_valid while busy
  task automatic run_one(input string req, input logic [A_W-1:0] a, input logic [B_W-1:0] b,
                         input bit sa, input bit sb, input bit fl, input int hold, input bit junk);
    logic [2*RW:0] e;
    int cyc;
    logic [RW-1:0] q0, r0;
    e = ref_div(a, b, sa, sb, fl);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_dividend = a; in_divisor = b; in_a_signed = sa; in_b_signed = sb; in_floor = fl;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    if (junk) begin
      in_valid = 1'b1; in_dividend = ~a; in_divisor = b + 6'd3; in_floor = ~fl;
    end
    cyc = 0;
    do begin
      @(posedge clk); cyc++; @(negedge clk);
    end while (!out_valid && cyc < 40);
    check({req, " R3 latency"}, cyc, RW + 1);
    check({req, " R2 no ready while result"}, in_ready, 0);
    q0 = out_quotient; r0 = out_remainder;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check({req, " R4 held quotient"}, out_quotient, q0);
      check({req, " R4 held remainder"}, out_remainder, r0);
    end
    in_valid = 1'b0;
    check({req, " quotient"}, out_quotient, e[2*RW-1:RW]);
    check({req, " remainder"}, out_remainder, e[RW-1:0]);
    check({req, " R9 div-zero flag"}, out_div_zero, e[2*RW]);
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check({req, " R4 release valid"}, out_valid, 0);
    check({req, " R4 release ready"}, in_ready, 1);
  endtask

  initial begin
    repeat (400000) @(posedge clk);
    if (!done_flag) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset in_ready", in_ready, 1);
    check("R1 reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset in_ready", in_ready, 1);

    run_one("R5 7/2 trunc",          8'd7,    6'd2,    1, 1, 0, 0, 0);
    run_one("R5 -7/2 trunc",         8'hF9,   6'd2,    1, 1, 0, 0, 0);
    run_one("R6 -7/2 floor",         8'hF9,   6'd2,    1, 1, 1, 0, 0);
    run_one("R6 7/-2 floor",         8'd7,    6'h3E,   1, 1, 1, 0, 0);
    run_one("R6 -7/-2 floor same",   8'hF9,   6'h3E,   1, 1, 1, 0, 0);
    run_one("R6 -8/2 floor exact",   8'hF8,   6'd2,    1, 1, 1, 0, 0);
    run_one("R7 unsigned a flag",    8'h80,   6'h3E,   1, 0, 1, 0, 0);
    run_one("R7 unsigned b flag",    8'hF9,   6'd2,    0, 1, 1, 0, 0);
    run_one("R8 dz unsigned",        8'h5A,   6'd0,    0, 0, 0, 0, 0);
    run_one("R8 dz signed pos",      8'h25,   6'd0,    1, 1, 1, 0, 0);
    run_one("R9 dz signed neg",      8'hA5,   6'd0,    1, 1, 0, 0, 0);
    run_one("R9 dz unsigned hi",     8'hE7,   6'd0,    1, 0, 0, 0, 0);
    run_one("R10 minneg/-1",         8'h80,   6'h3F,   1, 1, 0, 0, 0);
    run_one("R10 minneg/-1 floor",   8'h80,   6'h3F,   1, 1, 1, 0, 0);
    run_one("R2 R4 junk and hold",   8'h9C,   6'h05,   1, 1, 1, 4, 1);
    run_one("R2 next after junk",    8'd100,  6'd7,    0, 0, 0, 0, 0);

    for (int t = 0; t < 400; t++) begin
      logic [A_W-1:0] ra;
      logic [B_W-1:0] rb;
      bit rsa, rsb, rfl;
      ra  = A_W'($urandom);
      rb  = ($urandom_range(0, 15) == 0) ? '0 : B_W'($urandom);
      rsa = ($urandom_range(0, 3) != 0);
      rsb = ($urandom_range(0, 3) != 0);
      rfl = $urandom_range(0, 1) == 1;
      run_one("R5 R6 R7 random", ra, rb, rsa, rsb, rfl,
              $urandom_range(0, 2), ($urandom_range(0, 3) == 0));
    end

    done_flag = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule